// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a synthesized clock is frequency-locked to a reference clock, and it drives an active-high loss-of-lock flag. A divided-down copy of the synthesized output runs freely in its own clock domain. The block counts the edges of that divided clock over a fixed gate of reference-clock cycles. It compares the count with the nominal value for the selected divide relationship and also reports the signed difference.

Two thresholds set in counts give the decision its hysteresis. A wide threshold takes a locked loop out of lock. A narrower threshold must be met before the flag clears again. A power-down/calibrate hold forces the flag low and restarts the measurement. When the hold is released, the flag is raised again and stays raised until a complete clean window has been seen. The divided clock may be asynchronous to the reference and may have any phase relative to it. Its count crosses into the reference domain as a Gray code through a two-flop synchronizer.

Top module: `freq_lock_monitor`

## Requirements
- R1: `lolFlag` is active high. It is 1 during reset and after reset is released, and it does not clear before one full measurement window has completed within the lock-in threshold.
- R2: A window lasts 2^GATE_LOG2 reference cycles. At the end of each window, `freqErr` is updated to the number of divided-clock rising edges counted minus the nominal count (2^GATE_LOG2 << ratioSel). The value is two's complement and is positive when the divided clock is fast. After reset, `freqErr` is 0.
- R3: While locked, a window with |error| >= (DROP_CNT << ratioSel) sets `lolFlag`.
- R4: While unlocked, `lolFlag` clears only after a window with |error| < (LOCK_CNT << ratioSel). An error that lies between the two thresholds leaves the flag in its current state, whichever state that is.
- R5: `ratioSel` = k selects a nominal divided frequency of 2^k times the reference. The nominal count and both thresholds scale by 2^k.
- R6: A window with no divided-clock edges sets `freqErr` to the most negative value of its width and sets `lolFlag`.
- R7: While `holdCal` is 1, `lolFlag` is 0 from that same cycle on, and no window is evaluated whatever the divided frequency is.
- R8: After `holdCal` falls, `lolFlag` is 1 at once. A fresh window starts from the release, and lock needs a full clean window.
- R9: A divided clock that is slow by more than the drop threshold gives a negative `freqErr` and loses lock in the same way as a fast one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all decisions are made in this domain |
| divClk | input | 1 | Divided copy of the synthesized output, asynchronous to refClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| ratioSel | input | RATIO_W | Log2 of nominal divided-to-reference frequency ratio |
| holdCal | input | 1 | Power-down/calibrate hold, active high |
| lolFlag | output | 1 | Loss-of-lock flag, active high |
| freqErr | output | ERR_W | Signed count error of the last completed window |

## Verification
A corrupted baseline or gate counter shows at the ports within one window as a wrong `freqErr` value, or as a flag transition that happens a window too early or too late. A wrong hysteresis state shows only when the error sits between the two thresholds, so the bench holds errors in that band from both the locked and the unlocked side. A mishandled hold release shows up within two cycles as a flag that stays low. It also shows up one window later as a lock that was taken without a clean window.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearBase;  // keep re-arming the window baseline
    logic endWindow;  // close current window this cycle
  } lockdet_ctrl_t;

  // Results of a window evaluation, one cycle after endWindow
  typedef struct packed {
    logic evalValid;
    logic overDrop;   // error at or beyond the drop threshold
    logic underLock;  // error strictly inside the lock-in threshold
  } lockdet_stat_t;

  typedef enum logic {
    ST_SEEK   = 1'b0,
    ST_LOCKED = 1'b1
  } lockdet_state_e;

endpackage

// File: rtl/lockdet_gray_xfer.sv
module lockdet_gray_xfer #(
  parameter int CNT_W = 16
) (
  input  logic             divClk,
  input  logic             refClk,
  input  logic             rstN,
  output logic [CNT_W-1:0] refCount
);

  logic [CNT_W-1:0] binCnt;
  logic [CNT_W-1:0] binNext;
  logic [CNT_W-1:0] grayQ;
  logic [CNT_W-1:0] syncA;
  logic [CNT_W-1:0] syncB;

  assign binNext = binCnt + CNT_W'(1);

  // Divided-clock domain: free-running edge counter and its Gray image
  always_ff @(posedge divClk or negedge rstN) begin
    if (!rstN) begin
      binCnt <= '0;
      grayQ  <= '0;
    end else begin
      binCnt <= binNext;
      grayQ  <= binNext ^ (binNext >> 1);
    end
  end

  // Reference domain: two-flop synchronizer
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= grayQ;
      syncB <= syncA;
    end
  end

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  assign refCount = grayToBin(syncB);

endmodule

// File: rtl/lockdet_datapath.sv
module lockdet_datapath
  import lockdet_pkg::*;
#(
  parameter int GATE_LOG2 = 16,
  parameter int RATIO_W   = 2,
  parameter int DROP_CNT  = 39,
  parameter int LOCK_CNT  = 20,
  localparam int CNT_W    = GATE_LOG2 + (1 << RATIO_W) + 1,
  localparam int ERR_W    = CNT_W + 1
) (
  input  logic                    refClk,
  input  logic                    divClk,
  input  logic                    rstN,
  input  logic [RATIO_W-1:0]      ratioSel,
  input  lockdet_ctrl_t           ctrl,
  output logic signed [ERR_W-1:0] freqErr,
  output lockdet_stat_t           stat
);

  localparam logic [CNT_W-1:0] GATE_CNT = CNT_W'(1) << GATE_LOG2;
  localparam logic [ERR_W-1:0] ERR_MIN  = {1'b1, {(ERR_W-1){1'b0}}};

  logic [CNT_W-1:0]        refCount;
  logic [CNT_W-1:0]        baseCount;
  logic [CNT_W-1:0]        winCount;
  logic [CNT_W-1:0]        expected;
  logic [CNT_W-1:0]        magnitude;
  logic [CNT_W-1:0]        dropTh;
  logic [CNT_W-1:0]        lockTh;
  logic                    noEdges;
  logic signed [ERR_W-1:0] errNext;

  lockdet_gray_xfer #(.CNT_W(CNT_W)) u_xfer (
    .divClk   (divClk),
    .refClk   (refClk),
    .rstN     (rstN),
    .refCount (refCount)
  );

  always_comb begin
    winCount  = refCount - baseCount;
    expected  = GATE_CNT << ratioSel;
    dropTh    = CNT_W'(DROP_CNT) << ratioSel;
    lockTh    = CNT_W'(LOCK_CNT) << ratioSel;
    noEdges   = (winCount == '0);
    magnitude = (winCount >= expected) ? (winCount - expected)
                                       : (expected - winCount);
    if (noEdges) begin
      errNext = ERR_MIN;
    end else begin
      errNext = $signed({1'b0, winCount}) - $signed({1'b0, expected});
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      baseCount <= '0;
      freqErr   <= '0;
      stat      <= '0;
    end else begin
      stat.evalValid <= 1'b0;
      if (ctrl.clearBase) begin
        baseCount <= refCount;
      end else if (ctrl.endWindow) begin
        baseCount      <= refCount;
        freqErr        <= errNext;
        stat.evalValid <= 1'b1;
        stat.overDrop  <= noEdges || (magnitude >= dropTh);
        stat.underLock <= !noEdges && (magnitude < lockTh);
      end
    end
  end

endmodule

// File: rtl/lockdet_ctrl.sv
module lockdet_ctrl
  import lockdet_pkg::*;
#(
  parameter int GATE_LOG2 = 16
) (
  input  logic          refClk,
  input  logic          rstN,
  input  logic          holdCal,
  input  lockdet_stat_t stat,
  output lockdet_ctrl_t ctrl,
  output logic          lolFlag
);

  logic [GATE_LOG2-1:0] gateCnt;
  lockdet_state_e       state;
  lockdet_state_e       stateNext;

  assign ctrl.clearBase = holdCal;
  assign ctrl.endWindow = !holdCal && (gateCnt == '1);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      gateCnt <= '0;
    end else if (holdCal) begin
      gateCnt <= '0;
    end else begin
      gateCnt <= gateCnt + GATE_LOG2'(1);
    end
  end

  always_comb begin
    stateNext = state;
    if (holdCal) begin
      stateNext = ST_SEEK;
    end else if (stat.evalValid) begin
      unique case (state)
        ST_SEEK:   if (stat.underLock) stateNext = ST_LOCKED;
        ST_LOCKED: if (stat.overDrop)  stateNext = ST_SEEK;
        default:   stateNext = ST_SEEK;
      endcase
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_SEEK;
    end else begin
      state <= stateNext;
    end
  end

  assign lolFlag = (state == ST_SEEK) && !holdCal;

endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
  import lockdet_pkg::*;
#(
  parameter int GATE_LOG2 = 16,
  parameter int RATIO_W   = 2,
  parameter int DROP_CNT  = 39,
  parameter int LOCK_CNT  = 20,
  localparam int ERR_W    = GATE_LOG2 + (1 << RATIO_W) + 2
) (
  input  logic               refClk,
  input  logic               divClk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               holdCal,
  output logic               lolFlag,
  output logic [ERR_W-1:0]   freqErr
);

  lockdet_ctrl_t           dpCtrl;
  lockdet_stat_t           dpStat;
  logic signed [ERR_W-1:0] errSigned;

  lockdet_ctrl #(.GATE_LOG2(GATE_LOG2)) u_ctrl (
    .refClk  (refClk),
    .rstN    (rstN),
    .holdCal (holdCal),
    .stat    (dpStat),
    .ctrl    (dpCtrl),
    .lolFlag (lolFlag)
  );

  lockdet_datapath #(
    .GATE_LOG2 (GATE_LOG2),
    .RATIO_W   (RATIO_W),
    .DROP_CNT  (DROP_CNT),
    .LOCK_CNT  (LOCK_CNT)
  ) u_dp (
    .refClk   (refClk),
    .divClk   (divClk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .ctrl     (dpCtrl),
    .freqErr  (errSigned),
    .stat     (dpStat)
  );

  assign freqErr = errSigned;

endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int GATE_LOG2 = 16
) (
  input logic refClk,
  input logic rstN,
  input logic holdCal,
  input logic lolFlag,
  input logic evalValid,
  input logic overDrop,
  input logic underLock
);

  localparam int SW = GATE_LOG2 + 2;
  localparam logic [SW-1:0] GATE = SW'(1) << GATE_LOG2;

  logic [SW-1:0] sinceEval;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      sinceEval <= '0;
    end else if (holdCal) begin
      sinceEval <= '0;
    end else if (evalValid) begin
      sinceEval <= SW'(1);
    end else if (sinceEval <= GATE) begin
      sinceEval <= sinceEval + SW'(1);
    end
  end

  AST_HOLD_CLEARS_FLAG: assert property (@(posedge refClk) disable iff (!rstN)
    holdCal |-> !lolFlag); // R7

  AST_RELEASE_REARMS: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(holdCal) |-> lolFlag); // R8

  AST_LOCK_NEEDS_CLEAN_WINDOW: assert property (@(posedge refClk) disable iff (!rstN)
    (!holdCal && $fell(lolFlag)) |-> $past(evalValid && underLock)); // R4

  AST_DROP_NEEDS_BAD_WINDOW: assert property (@(posedge refClk) disable iff (!rstN)
    (!$past(holdCal) && $rose(lolFlag)) |-> $past(evalValid && overDrop)); // R3

  AST_WINDOW_SPACING: assert property (@(posedge refClk) disable iff (!rstN)
    evalValid |-> (sinceEval == GATE)); // R2

endmodule

bind freq_lock_monitor lockdet_checker #(.GATE_LOG2(GATE_LOG2)) u_lockdet_checker (
  .refClk    (refClk),
  .rstN      (rstN),
  .holdCal   (holdCal),
  .lolFlag   (lolFlag),
  .evalValid (dpStat.evalValid),
  .overDrop  (dpStat.overDrop),
  .underLock (dpStat.underLock)
);

// File: tb/tb_freq_lock_monitor.sv
`timescale 1ns/1ps
module tb_freq_lock_monitor;

  localparam int GATE_LOG2 = 10;
  localparam int RATIO_W   = 2;
  localparam int ERR_W     = GATE_LOG2 + (1 << RATIO_W) + 2;
  localparam int W         = 1 << GATE_LOG2;
  localparam int SETTLE    = 3 * W + 16;
  localparam int ERR_MIN   = -(1 << (ERR_W - 1));

  logic               refClk = 1'b0;
  logic               divClk = 1'b0;
  logic               rstN = 1'b0;
  logic [RATIO_W-1:0] ratioSel = '0;
  logic               holdCal = 1'b0;
  logic               lolFlag;
  logic [ERR_W-1:0]   freqErr;

  realtime divHalf = 2.5;
  bit      divRun = 1'b1;
  int      checks = 0;
  int      failures = 0;
  bit      done = 1'b0;

  typedef struct {
    string tag;
    logic  expLol;
    bit    chkErr;
    int    errLo;
    int    errHi;
  } exp_t;

  exp_t sbQ[$];
  event sampleEv;

  freq_lock_monitor #(
    .GATE_LOG2 (GATE_LOG2),
    .RATIO_W   (RATIO_W),
    .DROP_CNT  (12),
    .LOCK_CNT  (6)
  ) dut (
    .refClk   (refClk),
    .divClk   (divClk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .holdCal  (holdCal),
    .lolFlag  (lolFlag),
    .freqErr  (freqErr)
  );

  always #2.5 refClk = ~refClk;

  initial begin
    forever begin
      if (divRun) begin
        #(divHalf) divClk = ~divClk;
      end else begin
        #1.0;
      end
    end
  end

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      @(negedge refClk);
      while (sbQ.size() > 0) begin
        exp_t e;
        int   errVal;
        e = sbQ.pop_front();
        errVal = $signed(freqErr);
        checks++;
        if (lolFlag !== e.expLol) begin
          failures++;
          $display("FAIL %s lolFlag actual=%0b expected=%0b", e.tag, lolFlag, e.expLol);
        end
        if (e.chkErr) begin
          checks++;
          if (errVal < e.errLo || errVal > e.errHi) begin
            failures++;
            $display("FAIL %s freqErr actual=%0d expected=[%0d,%0d]",
                     e.tag, errVal, e.errLo, e.errHi);
          end
        end
      end
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic expectNow(input string tag, input logic lol, input bit chk,
                           input int lo, input int hi);
    exp_t e;
    e.tag = tag; e.expLol = lol; e.chkErr = chk; e.errLo = lo; e.errHi = hi;
    sbQ.push_back(e);
    -> sampleEv;
    waitCycles(2);
  endtask

  // Divided-clock half period for a given ratio and count error per window
  task automatic setErr(input int ratio, input int err);
    int nom;
    nom = W << ratio;
    divHalf = (2.5 * nom) / ((nom + err) * (1 << ratio));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    waitCycles(10);
    expectNow("R1 reset flag and R2 reset error", 1'b1, 1'b1, 0, 0);
    rstN = 1'b1;
    setErr(0, 0);
    waitCycles(600);
    expectNow("R1 no lock before first window", 1'b1, 1'b0, 0, 0);
    waitCycles(SETTLE);
    expectNow("R2 lock at nominal", 1'b0, 1'b1, -2, 2);

    setErr(0, 9);
    waitCycles(SETTLE);
    expectNow("R4 between thresholds stays locked", 1'b0, 1'b1, 7, 11);
    setErr(0, 30);
    waitCycles(SETTLE);
    expectNow("R3 drop on fast clock", 1'b1, 1'b1, 28, 32);
    setErr(0, 9);
    waitCycles(SETTLE);
    expectNow("R4 between thresholds stays unlocked", 1'b1, 1'b1, 7, 11);
    setErr(0, 0);
    waitCycles(SETTLE);
    expectNow("R4 relock inside lock-in", 1'b0, 1'b1, -2, 2);

    setErr(0, -30);
    waitCycles(SETTLE);
    expectNow("R9 drop on slow clock", 1'b1, 1'b1, -32, -28);
    setErr(0, 0);
    waitCycles(SETTLE);
    expectNow("R9 relock after slow", 1'b0, 1'b0, 0, 0);

    holdCal = 1'b1;
    expectNow("R7 flag low in hold", 1'b0, 1'b0, 0, 0);
    setErr(0, 30);
    waitCycles(SETTLE);
    expectNow("R7 bad frequency ignored in hold", 1'b0, 1'b0, 0, 0);
    setErr(0, 0);
    holdCal = 1'b0;
    expectNow("R8 flag raised on release", 1'b1, 1'b0, 0, 0);
    waitCycles(600);
    expectNow("R8 no lock before fresh window", 1'b1, 1'b0, 0, 0);
    waitCycles(SETTLE);
    expectNow("R8 lock after clean window", 1'b0, 1'b1, -2, 2);

    divRun = 1'b0;
    waitCycles(SETTLE);
    expectNow("R6 no edges gives max error", 1'b1, 1'b1, ERR_MIN, ERR_MIN);

    ratioSel = 2'd1;
    setErr(1, 0);
    divRun = 1'b1;
    waitCycles(SETTLE);
    expectNow("R5 lock at ratio two", 1'b0, 1'b1, -2, 2);
    setErr(1, 18);
    waitCycles(SETTLE);
    expectNow("R5 scaled drop threshold holds lock", 1'b0, 1'b1, 16, 20);
    setErr(1, 30);
    waitCycles(SETTLE);
    expectNow("R5 scaled drop exceeded", 1'b1, 1'b1, 28, 32);

    waitCycles(4);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge refClk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

endmodule